// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Unit

This block decides, for each instruction in the execute stage of a five-stage in-order pipeline, where its two ALU operands come from. Each operand can come from the register file, from the result held in the execute/memory boundary register, or from the value about to be written back. When an instruction that reads memory sits in execute and the instruction being decoded needs the register it loads, the block also holds fetch and decode for one cycle and turns the instruction entering execute into a no-op.

Every output is a pure combinational function of the register numbers and control bits in the pipeline registers, so the selects and stall controls settle in the same cycle as their inputs. The surrounding pipeline uses `pc_we` and `dec_we` as write enables on the program counter and the fetch/decode register, and `ex_kill` to clear the control fields written into the decode/execute register.

Top module: `bypass_ctl`

## Requirements
- R1: `sel_a` is 2'b10 when `mem_wr_en` is 1, `mem_dst` is not 0 and `mem_dst` equals `ex_src_a`.
- R2: `sel_b` is 2'b10 when `mem_wr_en` is 1, `mem_dst` is not 0 and `mem_dst` equals `ex_src_b`.
- R3: An operand select is 2'b01 when `wb_wr_en` is 1, `wb_dst` is not 0, `wb_dst` equals that operand's source register, and the R1/R2 condition for that operand is false.
- R4: When both the memory-stage and write-back-stage results match the same operand, the select is 2'b10, so the newer result wins.
- R5: A stage whose write enable is 0, or whose destination is register 0, never causes forwarding; with no match a select is 2'b00 (register file).
- R6: When `ex_load` is 1 and `ex_src_b` equals `dec_src_a` or `dec_src_b` (register 0 included), `pc_we` and `dec_we` are 0 and `ex_kill` is 1.
- R7: When the R6 condition is false, `pc_we` and `dec_we` are 1 and `ex_kill` is 0.
- R8: The value 2'b11 never appears on `sel_a` or `sel_b`.
- R9: In a running pipeline, a load followed at once by a user of its result costs exactly one bubble; the held instruction is decoded again and, once in execute, takes the loaded value with select 2'b01. A load whose user is two instructions later costs no bubble and is forwarded with 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src_a | input | REG_W | First source register of the instruction in decode |
| dec_src_b | input | REG_W | Second source register of the instruction in decode |
| ex_src_a | input | REG_W | First source register of the instruction in execute |
| ex_src_b | input | REG_W | Second source register of the instruction in execute (load destination for loads) |
| ex_load | input | 1 | Instruction in execute reads data memory |
| mem_wr_en | input | 1 | Instruction in the memory stage writes the register file |
| mem_dst | input | REG_W | Destination register of the memory-stage instruction |
| wb_wr_en | input | 1 | Instruction in write-back writes the register file |
| wb_dst | input | REG_W | Destination register of the write-back instruction |
| sel_a | output | 2 | Operand A source: 00 register file, 10 memory stage, 01 write-back |
| sel_b | output | 2 | Operand B source, same encoding |
| pc_we | output | 1 | Program counter write enable |
| dec_we | output | 1 | Fetch/decode register write enable |
| ex_kill | output | 1 | Zero the control fields entering execute |

## Verification
The checker confirms on every evaluation that the selects never take the unused code, that a memory-stage match always wins over a write-back match, that write-back forwarding only ever comes from a writing, non-zero destination, and that a stall only appears with a load in execute. What those checks cannot show is the behaviour over time in a pipeline: that the held instruction is decoded again, that exactly one bubble is inserted, and that the loaded value then reaches the stalled instruction through the write-back path. The bench shows that with a small pipeline-register model driven by the block's own stall outputs, after a near-exhaustive sweep of register-number patterns.

// File: rtl/bypass_ctl.sv
module bypass_ctl #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] dec_src_a,
  input  logic [REG_W-1:0] dec_src_b,
  input  logic [REG_W-1:0] ex_src_a,
  input  logic [REG_W-1:0] ex_src_b,
  input  logic             ex_load,
  input  logic             mem_wr_en,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             wb_wr_en,
  input  logic [REG_W-1:0] wb_dst,
  output logic [1:0]       sel_a,
  output logic [1:0]       sel_b,
  output logic             pc_we,
  output logic             dec_we,
  output logic             ex_kill
);

  localparam logic [REG_W-1:0] ZERO_REG = '0;
  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_WB  = 2'b01;
  localparam logic [1:0] SEL_MEM = 2'b10;

  logic mem_live, wb_live;
  logic mem_hit_a, mem_hit_b, wb_hit_a, wb_hit_b;
  logic load_use;

  assign mem_live = mem_wr_en && (mem_dst != ZERO_REG);
  assign wb_live  = wb_wr_en  && (wb_dst  != ZERO_REG);

  assign mem_hit_a = mem_live && (mem_dst == ex_src_a);
  assign mem_hit_b = mem_live && (mem_dst == ex_src_b);
  assign wb_hit_a  = wb_live  && (wb_dst  == ex_src_a);
  assign wb_hit_b  = wb_live  && (wb_dst  == ex_src_b);

  assign sel_a = mem_hit_a ? SEL_MEM : (wb_hit_a ? SEL_WB : SEL_RF);
  assign sel_b = mem_hit_b ? SEL_MEM : (wb_hit_b ? SEL_WB : SEL_RF);

  assign load_use = ex_load && ((ex_src_b == dec_src_a) || (ex_src_b == dec_src_b));

  assign pc_we   = !load_use;
  assign dec_we  = !load_use;
  assign ex_kill = load_use;

endmodule

// File: rtl/bypass_ctl_chk.sv
module bypass_ctl_chk #(
  parameter int REG_W = 5
) (
  input logic [REG_W-1:0] dec_src_a,
  input logic [REG_W-1:0] dec_src_b,
  input logic [REG_W-1:0] ex_src_a,
  input logic [REG_W-1:0] ex_src_b,
  input logic             ex_load,
  input logic             mem_wr_en,
  input logic [REG_W-1:0] mem_dst,
  input logic             wb_wr_en,
  input logic [REG_W-1:0] wb_dst,
  input logic [1:0]       sel_a,
  input logic [1:0]       sel_b,
  input logic             pc_we,
  input logic             dec_we,
  input logic             ex_kill
);

  always_comb begin
    assert_sel_code_legal_R8: assert (sel_a != 2'b11 && sel_b != 2'b11);
    assert_newest_wins_a_R4: assert (!(mem_wr_en && mem_dst != '0 && mem_dst == ex_src_a) || sel_a == 2'b10);
    assert_newest_wins_b_R4: assert (!(mem_wr_en && mem_dst != '0 && mem_dst == ex_src_b) || sel_b == 2'b10);
    assert_wb_src_valid_R5: assert ((sel_a != 2'b01 || (wb_wr_en && wb_dst != '0 && wb_dst == ex_src_a))
                                 && (sel_b != 2'b01 || (wb_wr_en && wb_dst != '0 && wb_dst == ex_src_b)));
    assert_mem_src_valid_R5: assert ((sel_a != 2'b10 || mem_wr_en) && (sel_b != 2'b10 || mem_wr_en));
    assert_stall_needs_load_R6: assert (!ex_kill || ex_load);
    assert_stall_consistent_R6: assert (pc_we == dec_we && ex_kill == !pc_we);
    assert_free_run_R7: assert (ex_load || (pc_we && dec_we && !ex_kill));
  end

endmodule

bind bypass_ctl bypass_ctl_chk #(.REG_W(REG_W)) i_bypass_ctl_chk (.*);

// File: tb/test_bypass_ctl.sv
module test_bypass_ctl;
  localparam int RW = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [RW-1:0] dec_src_a, dec_src_b, ex_src_a, ex_src_b, mem_dst, wb_dst;
  logic ex_load, mem_wr_en, wb_wr_en;
  logic [1:0] sel_a, sel_b;
  logic pc_we, dec_we, ex_kill;

  bypass_ctl #(.REG_W(RW)) i_bypass_ctl (.*);

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      done = 1;
      failures = failures + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [RW-1:0] rv(input int k);
    return (k == 3) ? RW'(31) : RW'(k);
  endfunction

  // Pipeline model: program of 6 instructions, index -1 is a no-op.
  int p_rs[6]  = '{5, 1, 2, 0, 7, 6};
  int p_rt[6]  = '{1, 3, 1, 6, 8, 6};
  int p_dst[6] = '{1, 2, 4, 6, 9, 10};
  bit p_ld[6]  = '{1, 0, 0, 1, 0, 0};
  int pc, f_i, x_i, m_i, w_i;

  task automatic drive_model();
    dec_src_a = (f_i < 0) ? '0 : RW'(p_rs[f_i]);
    dec_src_b = (f_i < 0) ? '0 : RW'(p_rt[f_i]);
    ex_src_a  = (x_i < 0) ? '0 : RW'(p_rs[x_i]);
    ex_src_b  = (x_i < 0) ? '0 : RW'(p_rt[x_i]);
    ex_load   = (x_i < 0) ? 1'b0 : p_ld[x_i];
    mem_wr_en = (m_i >= 0);
    mem_dst   = (m_i < 0) ? '0 : RW'(p_dst[m_i]);
    wb_wr_en  = (w_i >= 0);
    wb_dst    = (w_i < 0) ? '0 : RW'(p_dst[w_i]);
  endtask

  task automatic step();
    bit pw, dw, kl;
    pw = pc_we; dw = dec_we; kl = ex_kill;
    @(posedge clk);
    w_i = m_i;
    m_i = x_i;
    x_i = kl ? -1 : f_i;
    if (dw) f_i = (pc < 6) ? pc : -1;
    if (pw) pc = pc + 1;
    drive_model();
    @(negedge clk);
  endtask

  initial begin
    int bubbles;
    int ea, eb, es;
    string ta, tb, ts;
    bit ha, hb, wa, wb;

    // reset state: empty pipeline
    pc = 0; f_i = -1; x_i = -1; m_i = -1; w_i = -1;
    drive_model();
    @(negedge clk);
    chk("R5 reset sel_a", sel_a, 0);
    chk("R5 reset sel_b", sel_b, 0);
    chk("R7 reset pc_we", pc_we, 1);
    chk("R7 reset dec_we", dec_we, 1);
    chk("R7 reset ex_kill", ex_kill, 0);

    // near-exhaustive sweep: register numbers from {0,1,2,31}
    for (int m = 0; m < 32768; m++) begin
      dec_src_a = rv(m & 3);
      dec_src_b = rv((m >> 2) & 3);
      ex_src_a  = rv((m >> 4) & 3);
      ex_src_b  = rv((m >> 6) & 3);
      mem_dst   = rv((m >> 8) & 3);
      wb_dst    = rv((m >> 10) & 3);
      ex_load   = m[12];
      mem_wr_en = m[13];
      wb_wr_en  = m[14];
      #1;
      ha = mem_wr_en && mem_dst != 0 && mem_dst == ex_src_a;
      hb = mem_wr_en && mem_dst != 0 && mem_dst == ex_src_b;
      wa = wb_wr_en && wb_dst != 0 && wb_dst == ex_src_a;
      wb = wb_wr_en && wb_dst != 0 && wb_dst == ex_src_b;
      ea = ha ? 2 : (wa ? 1 : 0);
      eb = hb ? 2 : (wb ? 1 : 0);
      ta = (ha && wa) ? "R4 sel_a" : ha ? "R1 sel_a" : wa ? "R3 sel_a" : "R5 sel_a";
      tb = (hb && wb) ? "R4 sel_b" : hb ? "R2 sel_b" : wb ? "R3 sel_b" : "R5 sel_b";
      es = (ex_load && (ex_src_b == dec_src_a || ex_src_b == dec_src_b)) ? 1 : 0;
      ts = es ? "R6 stall" : "R7 stall";
      chk(ta, sel_a, ea);
      chk(tb, sel_b, eb);
      chk(ts, {pc_we, dec_we, ex_kill}, es ? 3'b001 : 3'b110);
      chk("R8 no code 11", (sel_a == 2'b11 || sel_b == 2'b11) ? 1 : 0, 0);
    end

    // pipeline scenario
    pc = 0; f_i = -1; x_i = -1; m_i = -1; w_i = -1;
    drive_model();
    @(negedge clk);
    bubbles = 0;
    step();                                   // load in decode
    step();                                   // load in execute, user in decode
    chk("R6 stall pc_we", pc_we, 0);
    chk("R6 stall dec_we", dec_we, 0);
    chk("R6 stall ex_kill", ex_kill, 1);
    bubbles += ex_kill;
    step();                                   // bubble in execute, user held
    chk("R9 user held in decode", f_i, 1);
    chk("R9 execute is bubble", x_i, -1);
    chk("R9 single bubble", ex_kill, 0);
    bubbles += ex_kill;
    step();                                   // user in execute, load in write-back
    chk("R9 user in execute", x_i, 1);
    chk("R9 loaded value via write-back", sel_a, 1);
    chk("R9 other operand from file", sel_b, 0);
    bubbles += ex_kill;
    step();
    chk("R1 producer in memory stage", sel_a, 2);
    chk("R5 no match operand B", sel_b, 0);
    bubbles += ex_kill;
    for (int k = 0; k < 6; k++) begin
      step();
      bubbles += ex_kill;
      if (x_i == 5) begin
        chk("R9 distant load sel_a", sel_a, 1);
        chk("R9 distant load sel_b", sel_b, 1);
      end
    end
    chk("R9 total bubbles", bubbles, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule